// File: doc/BRIEF.md
# Dual-Space I2C Target Controller

This block is the target side of an I2C bus and gives access to two storage areas on one pair of lines. One is a byte-wide memory array. The other is a small bank of special function registers. Each area answers to its own device ID and keeps its own address pointer, so a master can break into a memory transfer, read or write a register, and then carry on reading memory with no new address. SCL and SDA are sampled by the system clock, which must run much faster than SCL. The block finds Start, repeated Start and Stop conditions on the sampled lines and drives SDA only through an open-drain enable.

A write loads the pointer of the chosen area from the address bytes that follow the slave address, then stores any data bytes from that point. A read either continues from the current pointer, or, when it follows a write that held only address bytes, starts from the address just loaded. This gives the random read. After each byte moved, the pointer steps forward and wraps at the top of its area. Both areas are plain synchronous arrays with no reset of their contents.

Top module: `i2c_dual_target`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` is 0 and the target drives nothing until it sees a matching slave address.
- R2: A slave address byte is acknowledged only if bits 7:4 equal `MEM_ID` (default 4'b1010) or `REG_ID` (default 4'b1101). Bits 3:1 are ignored. For any other ID the target gives no acknowledge and leaves SDA released for every later clock until the next Start or Stop.
- R3: Bit 0 of the slave address byte sets the direction: 0 is a write and 1 is a read.
- R4: A memory write sends two address bytes, high byte first. The pointer takes the low `MEM_AW` bits (13 by default) of the 16-bit value, and the upper bits are ignored.
- R5: A register write sends one address byte. The register pointer takes its low `REG_AW` bits (4 by default).
- R6: Every address and data byte of a write is acknowledged. Data bytes are stored one after another, starting at the loaded address.
- R7: A Start that comes after the address bytes of a write ends the write and stores no data. A read slave address that follows returns data from the address just loaded.
- R8: In a read, the target drives each byte MSB first. It keeps sending further bytes as long as the master acknowledges.
- R9: When the master does not acknowledge a read byte, the target releases SDA and drives nothing until the next Start or Stop.
- R10: A read that is given only the slave address returns data from the current pointer of the selected area.
- R11: The memory pointer and the register pointer are independent. A register transfer that breaks into a memory read leaves the memory pointer where that read stopped.
- R12: The selected pointer goes up by one after every byte written or read. It wraps to 0 after the last location of its area (8191 for memory, 15 for registers).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which also samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A wrong pointer shows at the ports only on the next read of that area. It comes out as a wrong byte on the first data byte after the slave address, or on a later byte if only the increment or the wrap is faulty. So the tests write known patterns across the top edge of each area and read them back after transfers to the other area. A bad state decode shows up sooner: it gives a missing or extra acknowledge within the same byte, or SDA held low after a not-acknowledge.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_IGN
  } tgt_state_t;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;
endpackage

// File: rtl/i2c_dt_line.sv
module i2c_dt_line #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q;
  logic scl_now, sda_now;

  assign scl_now = scl_sh[SYNC-1];
  assign sda_now = sda_sh[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh  <= '1;
      sda_sh  <= '1;
      scl_q   <= 1'b1;
      sda_lvl <= 1'b1;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
    end else begin
      scl_sh  <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh  <= {sda_sh[SYNC-2:0], sda_i};
      scl_q   <= scl_now;
      sda_lvl <= sda_now;
      // data edge while clock is high marks a bus condition
      start_p <= scl_now & scl_q & sda_lvl & ~sda_now;
      stop_p  <= scl_now & scl_q & ~sda_lvl & sda_now;
      rise_p  <= ~scl_q & scl_now;
      fall_p  <= scl_q & ~scl_now;
    end
  end
endmodule

// File: rtl/i2c_dt_ram.sv
module i2c_dt_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
  import i2c_dt_pkg::*;
#(
  parameter logic [3:0] MEM_ID = 4'b1010,
  parameter logic [3:0] REG_ID = 4'b1101,
  parameter int MEM_AW = 13,
  parameter int REG_AW = 4,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int FULL_AW = 2 * BYTE_W;
  localparam logic [BIT_CNT_W-1:0] CNT_BYTE = BIT_CNT_W'(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] CNT_ACK  = BIT_CNT_W'(BYTE_W + 1);

  tgt_state_t state;
  logic [BIT_CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shreg, ahi;
  logic sel_reg;
  logic [MEM_AW-1:0] mem_ptr, wr_addr;
  logic [REG_AW-1:0] reg_ptr;
  logic [BYTE_W-1:0] wr_data;
  logic mem_we, reg_we;
  logic [BYTE_W-1:0] mem_rd, reg_rd, rd_byte;
  logic [FULL_AW-1:0] addr_full;
  logic sda_lvl, start_p, stop_p, rise_p, fall_p;
  logic id_mem, id_reg;

  i2c_dt_line #(.SYNC(SYNC)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .start_p(start_p), .stop_p(stop_p),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  i2c_dt_ram #(.AW(MEM_AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(mem_ptr), .rdata(mem_rd)
  );

  i2c_dt_ram #(.AW(REG_AW), .DW(BYTE_W)) u_reg (
    .clk(clk), .we(reg_we), .waddr(wr_addr[REG_AW-1:0]), .wdata(wr_data),
    .raddr(reg_ptr), .rdata(reg_rd)
  );

  assign rd_byte   = sel_reg ? reg_rd : mem_rd;
  assign addr_full = {ahi, shreg};
  assign id_mem    = (shreg[7:4] == MEM_ID);
  assign id_reg    = (shreg[7:4] == REG_ID);

  always_ff @(posedge clk) begin
    mem_we <= 1'b0;
    reg_we <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ahi     <= '0;
      sel_reg <= 1'b0;
      mem_ptr <= '0;
      reg_ptr <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else if (start_p) begin
      state  <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_IGN: sda_oe <= 1'b0;
        ST_RD: begin
          if (fall_p) begin
            if (cnt == CNT_ACK) begin
              // master acked: put out the next byte, MSB first
              shreg  <= rd_byte;
              sda_oe <= ~rd_byte[7];
              cnt    <= BIT_CNT_W'(1);
            end else if (cnt == CNT_BYTE) begin
              sda_oe <= 1'b0;
              cnt    <= CNT_ACK;
              if (sel_reg) reg_ptr <= reg_ptr + REG_AW'(1);
              else         mem_ptr <= mem_ptr + MEM_AW'(1);
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              cnt    <= cnt + BIT_CNT_W'(1);
            end
          end else if (rise_p && cnt == CNT_ACK && sda_lvl) begin
            state <= ST_IGN;
          end
        end
        default: begin
          if (rise_p && cnt < CNT_BYTE) begin
            shreg <= {shreg[6:0], sda_lvl};
            cnt   <= cnt + BIT_CNT_W'(1);
          end else if (fall_p && cnt == CNT_ACK) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
          end else if (fall_p && cnt == CNT_BYTE) begin
            cnt    <= CNT_ACK;
            sda_oe <= 1'b1;
            case (state)
              ST_DEV: begin
                if (!id_mem && !id_reg) begin
                  state  <= ST_IGN;
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                end else begin
                  sel_reg <= id_reg;
                  if (shreg[0])    state <= ST_RD;
                  else if (id_reg) state <= ST_ALO;
                  else             state <= ST_AHI;
                end
              end
              ST_AHI: begin
                ahi   <= shreg;
                state <= ST_ALO;
              end
              ST_ALO: begin
                if (sel_reg) reg_ptr <= shreg[REG_AW-1:0];
                else         mem_ptr <= addr_full[MEM_AW-1:0];
                state <= ST_WR;
              end
              default: begin
                wr_data <= shreg;
                if (sel_reg) begin
                  wr_addr <= MEM_AW'(reg_ptr);
                  reg_we  <= 1'b1;
                  reg_ptr <= reg_ptr + REG_AW'(1);
                end else begin
                  wr_addr <= mem_ptr;
                  mem_we  <= 1'b1;
                  mem_ptr <= mem_ptr + MEM_AW'(1);
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_dual_target_chk.sv
module i2c_dual_target_chk #(
  parameter int MEM_AW = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              fall_p,
  input logic              start_p,
  input logic              in_ign,
  input logic              reg_busy,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_ptr,
  input logic [MEM_AW-1:0] wr_addr
);
  assert_reset_release_R1: assert property (@(posedge clk)
    rst |=> !sda_oe);

  assert_quiet_after_nack_R9: assert property (@(posedge clk) disable iff (rst)
    in_ign |-> !sda_oe);

  assert_drive_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(fall_p));

  assert_start_releases_R7: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !sda_oe);

  assert_mem_ptr_kept_R11: assert property (@(posedge clk) disable iff (rst)
    reg_busy |=> $stable(mem_ptr));

  assert_ptr_steps_R12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_ptr == wr_addr + MEM_AW'(1));
endmodule

bind i2c_dual_target i2c_dual_target_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk),
  .rst(rst),
  .sda_oe(sda_oe),
  .fall_p(fall_p),
  .start_p(start_p),
  .in_ign(state == i2c_dt_pkg::ST_IGN),
  .reg_busy(sel_reg && (state == i2c_dt_pkg::ST_AHI || state == i2c_dt_pkg::ST_ALO ||
                        state == i2c_dt_pkg::ST_WR || state == i2c_dt_pkg::ST_RD)),
  .mem_we(mem_we),
  .mem_ptr(mem_ptr),
  .wr_addr(wr_addr)
);

// File: tb/sim_i2c_dual_target.sv
module sim_i2c_dual_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [3:0] MID = 4'b1010;
  localparam logic [3:0] RID = 4'b1101;

  typedef struct {
    logic [7:0] val;
    string      req;
  } exp_t;

  logic clk = 0, rst = 1, scl = 1, msda = 1;
  logic sda_oe, sda_bus;
  int checks = 0, errors = 0;
  bit done = 0;

  exp_t exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] mem_m [8192];
  logic [7:0] reg_m [16];
  logic [12:0] mptr = 0;
  logic [3:0]  rptr = 0;

  assign sda_bus = msda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dual_target u0 (.clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pairs design output bytes with model predictions
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      check(g === e.val, e.req, int'(g), int'(e.val));
    end
  end

  task automatic wc(input int n); repeat (n) @(posedge clk); endtask

  task automatic bus_start;
    msda = 1; wc(Q); scl = 1; wc(Q); msda = 0; wc(Q); scl = 0; wc(Q);
  endtask

  task automatic bus_stop;
    msda = 0; wc(Q); scl = 1; wc(Q); msda = 1; wc(Q);
  endtask

  task automatic put_bit(input logic b);
    msda = b; wc(Q); scl = 1; wc(Q); scl = 0; wc(Q);
  endtask

  task automatic get_bit(output logic b);
    msda = 1; wc(Q); scl = 1; wc(Q/2); @(negedge clk); b = sda_bus; wc(Q/2); scl = 0; wc(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!ack);
  endtask

  task automatic send_dev(input bit is_reg, input bit rd, input string req);
    bit a;
    put_byte({(is_reg ? RID : MID), 3'b011, rd}, a);
    check(a == 1, req, a, 1);
  endtask

  task automatic send_addr(input bit is_reg, input logic [15:0] addr, input string req);
    bit a;
    if (!is_reg) begin
      put_byte(addr[15:8], a); check(a == 1, req, a, 1);
      mptr = addr[12:0];
    end else rptr = addr[3:0];
    put_byte(addr[7:0], a); check(a == 1, req, a, 1);
  endtask

  task automatic do_write(input bit is_reg, input logic [15:0] addr, input logic [7:0] d[], input string req);
    bit a;
    bus_start;
    send_dev(is_reg, 0, req);
    send_addr(is_reg, addr, req);
    foreach (d[i]) begin
      put_byte(d[i], a);
      check(a == 1, req, a, 1);
      if (is_reg) begin reg_m[rptr] = d[i]; rptr++; end
      else begin mem_m[mptr] = d[i]; mptr++; end
    end
    bus_stop;
  endtask

  task automatic read_bytes(input bit is_reg, input int n, input string req);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.req = req;
      if (is_reg) begin e.val = reg_m[rptr]; rptr++; end
      else begin e.val = mem_m[mptr]; mptr++; end
      exp_q.push_back(e);
      get_byte(v, i != n - 1);
      got_q.push_back(v);
    end
    bus_stop;
    wc(2);
  endtask

  task automatic rd_cur(input bit is_reg, input int n, input string req);
    bus_start;
    send_dev(is_reg, 1, req);
    read_bytes(is_reg, n, req);
  endtask

  task automatic rd_rand(input bit is_reg, input logic [15:0] addr, input int n, input string req);
    bus_start;
    send_dev(is_reg, 0, req);
    send_addr(is_reg, addr, req);
    bus_start;
    send_dev(is_reg, 1, req);
    read_bytes(is_reg, n, req);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", 1, 0);
    finish_run;
  end

  initial begin
    logic [7:0] v;
    bit a;
    wc(5);
    check(sda_oe == 0, "R1 reset", sda_oe, 0);
    rst = 0;
    wc(5);
    check(sda_oe == 0 && sda_bus == 1, "R1 idle", sda_oe, 0);

    // R2: foreign ID gets no ack and the bus stays released
    bus_start;
    put_byte(8'b0110_0001, a);
    check(a == 0, "R2 foreign id nack", a, 0);
    get_byte(v, 1);
    check(v == 8'hFF, "R2 ignored after mismatch", v, 8'hFF);
    bus_stop;

    // R4 R6 R12: memory write across the top edge
    do_write(0, 16'h1FFE, '{8'hA1, 8'hA2, 8'hA3}, "R6 mem write wrap");
    rd_rand(0, 16'h1FFE, 3, "R12 mem wrap read");
    // R5: register write wraps
    do_write(1, 16'h000E, '{8'h5A, 8'h5B, 8'h5C}, "R5 reg write");
    do_write(0, 16'h0100, '{8'h11, 8'h22, 8'h33, 8'h44}, "R6 mem write");
    // R7 R8: random read of two bytes
    rd_rand(0, 16'h0100, 2, "R8 random mem read");
    // R11: register access in between
    rd_rand(1, 16'h000E, 1, "R7 reg random read");
    rd_cur(0, 2, "R11 mem resumes");
    rd_cur(1, 2, "R10 reg current wrap");
    // R4: upper address bits ignored
    rd_rand(0, 16'hE100, 1, "R4 high bits ignored");

    // R7: aborted write stores nothing
    do_write(0, 16'h0200, '{8'h77}, "R6 seed");
    bus_start;
    send_dev(0, 0, "R7 abort");
    send_addr(0, 16'h0200, "R7 abort");
    bus_start;
    send_dev(0, 1, "R3 read dir");
    read_bytes(0, 1, "R7 abort keeps data");

    // R9: after nack the target stays quiet while clocks continue
    bus_start;
    send_dev(0, 1, "R9 setup");
    begin
      exp_t e;
      e.req = "R9 byte before nack";
      e.val = mem_m[mptr]; mptr++;
      exp_q.push_back(e);
      get_byte(v, 0);
      got_q.push_back(v);
    end
    get_byte(v, 1);
    check(v == 8'hFF, "R9 released after nack", v, 8'hFF);
    bus_stop;
    rd_cur(0, 1, "R10 mem current after nack");
    wc(20);
    check(exp_q.size() == 0, "R8 all bytes compared", exp_q.size(), 0);
    finish_run;
  end
endmodule